// File: doc/BRIEF.md
# Stack Pointer Transfer Unit

This block keeps the 16-bit stack pointer of a small 8-bit processor. It also executes the "reset stack pointer" instruction, whose behaviour is fixed when the block is built. In the fixed variant, the instruction returns the pointer to a start address set by a parameter. In the move variant, one processor flag, chosen by a parameter, sets the direction of a transfer:

- flag clear: the pointer is copied out to the register pair R1:R0;
- flag set: the pointer is loaded from R1:R0.

A supervisor option allows the instruction to act only while the processor's I-bit is set.

The block also serves the push and pop strobes of the stack. A push writes at the current pointer and then steps the pointer down. A pop steps the pointer up and reads at the new value, so the memory address for a pop is presented one above the current pointer in that same cycle. Instruction decode, the register file and the memory itself are outside the block. The block receives the current R1:R0 value and returns a write-back value with a one-cycle write strobe.

Top module: `sp_xfer_unit`

## Requirements
- R1: While reset is asserted and after it is released, the pointer equals START_ADDR, and the write-back strobe and the fault strobe are low.
- R2: With ALLOW_MOVE = 0, an accepted reset-pointer instruction sets the pointer to START_ADDR on the next clock edge and never raises the write-back strobe.
- R3: With ALLOW_MOVE = 1, only flag bit XFER_FLAG (default 4) of the 8-bit flag word selects the direction. The other seven flag bits have no effect.
- R4: With the selected flag at 0, the instruction raises the write-back strobe for exactly one cycle after the edge. The write-back value carries the pointer, with bits 15:8 for R1 and bits 7:0 for R0. The pointer is unchanged.
- R5: With the selected flag at 1, the pointer takes the R1:R0 input value (R1 in bits 15:8) at the next edge, and no write-back occurs.
- R6: With SUPERVISOR_EN = 1 and the I-bit at 0, the instruction changes neither the pointer nor the write-back port.
- R7: A lone push presents the current pointer as the memory address in the same cycle. The pointer is one lower after the edge.
- R8: A lone pop presents pointer + 1 as the memory address in the same cycle. The pointer is one higher after the edge.
- R9: A push and a pop in the same cycle leave the pointer unchanged and present the pointer as the address. They raise the fault strobe for exactly the one cycle after the edge.
- R10: An instruction that takes effect wins over a push or pop in the same cycle. The push or pop is dropped and raises no fault.
- R11: Pointer arithmetic wraps modulo 2^16: a pop at FFFF gives 0000, and a push at 0000 gives FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rspStrobe | input | 1 | Reset-stack-pointer instruction strobe |
| pushStrobe | input | 1 | Stack push strobe |
| popStrobe | input | 1 | Stack pop strobe |
| flags | input | 8 | Processor flag word |
| iBit | input | 1 | Processor I-bit |
| pairIn | input | 16 | Current R1:R0 value (R1 high) |
| stackPtr | output | 16 | Stack pointer |
| memAddr | output | 16 | Stack memory address for this cycle |
| pairOut | output | 16 | Write-back value for R1:R0 |
| pairWrite | output | 1 | One-cycle R1:R0 write strobe |
| stackFault | output | 1 | One-cycle push/pop collision fault |

## Verification
The memory address is combinational, so the bench compares it 1 ns after it drives the inputs, within the same cycle. The pointer, the write-back pair and the fault strobe each pass through one register. The bench therefore compares them at the falling edge after the rising edge that took the stimulus, and it expects each strobe back low one cycle later. A behavioural model advances once per cycle with the same timing. Two instances built with different parameters receive the same stimulus, so blocked, fixed and move behaviour are compared side by side.

// File: rtl/sp_xfer_pkg.sv
package sp_xfer_pkg;
  typedef struct packed {
    logic loadStart;
    logic loadPair;
    logic copyOut;
    logic push;
    logic pop;
    logic fault;
  } spCtrl_t;
endpackage

// File: rtl/sp_xfer_ctrl.sv
module sp_xfer_ctrl
  import sp_xfer_pkg::*;
#(
  parameter int FLAG_COUNT    = 8,
  parameter bit ALLOW_MOVE    = 1'b1,
  parameter int XFER_FLAG     = 4,
  parameter bit SUPERVISOR_EN = 1'b1
) (
  input  logic                  rspStrobe,
  input  logic                  pushStrobe,
  input  logic                  popStrobe,
  input  logic [FLAG_COUNT-1:0] flags,
  input  logic                  iBit,
  output spCtrl_t               ctrl
);
  logic rspActive;
  logic dirFlag;
  logic stackOnly;

  generate
    if (SUPERVISOR_EN) begin : g_sup
      assign rspActive = rspStrobe & iBit;
    end else begin : g_nosup
      assign rspActive = rspStrobe;
    end
  endgenerate

  generate
    if (ALLOW_MOVE) begin : g_move
      assign dirFlag = flags[XFER_FLAG];
    end else begin : g_fixed
      assign dirFlag = 1'b0;
    end
  endgenerate

  assign stackOnly = ~rspActive;

  always_comb begin
    ctrl = '0;
    if (rspActive) begin
      if (!ALLOW_MOVE)   ctrl.loadStart = 1'b1;
      else if (dirFlag)  ctrl.loadPair  = 1'b1;
      else               ctrl.copyOut   = 1'b1;
    end
    if (stackOnly) begin
      ctrl.fault = pushStrobe & popStrobe;
      ctrl.push  = pushStrobe & ~popStrobe;
      ctrl.pop   = popStrobe & ~pushStrobe;
    end
  end
endmodule

// File: rtl/sp_xfer_dp.sv
module sp_xfer_dp
  import sp_xfer_pkg::*;
#(
  parameter int              WIDTH      = 16,
  parameter logic [WIDTH-1:0] START_ADDR = 16'h0FF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  spCtrl_t          ctrl,
  input  logic [WIDTH-1:0] pairIn,
  output logic [WIDTH-1:0] stackPtr,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] pairOut,
  output logic             pairWrite,
  output logic             stackFault
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] spNext;

  always_comb begin
    spNext = stackPtr;
    if (ctrl.loadStart)     spNext = START_ADDR;
    else if (ctrl.loadPair) spNext = pairIn;
    else if (ctrl.push)     spNext = stackPtr - ONE;
    else if (ctrl.pop)      spNext = stackPtr + ONE;
  end

  assign memAddr = ctrl.pop ? stackPtr + ONE : stackPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr   <= START_ADDR;
      pairOut    <= '0;
      pairWrite  <= 1'b0;
      stackFault <= 1'b0;
    end else begin
      stackPtr   <= spNext;
      pairWrite  <= ctrl.copyOut;
      stackFault <= ctrl.fault;
      if (ctrl.copyOut) pairOut <= stackPtr;
    end
  end

  p_push_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.push |=> stackPtr == $past(stackPtr) - ONE);
  p_pop_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |=> stackPtr == $past(stackPtr) + ONE);
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fault |=> (stackPtr == $past(stackPtr)) && stackFault);
  p_copy_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.copyOut |=> pairWrite && (pairOut == $past(stackPtr)) && (stackPtr == $past(stackPtr)));
  p_wb_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.copyOut |=> !pairWrite);
  p_load_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadPair |=> stackPtr == $past(pairIn));
endmodule

// File: rtl/sp_xfer_unit.sv
module sp_xfer_unit
  import sp_xfer_pkg::*;
#(
  parameter int              WIDTH         = 16,
  parameter int              FLAG_COUNT    = 8,
  parameter logic [WIDTH-1:0] START_ADDR    = 16'h0FF0,
  parameter bit              ALLOW_MOVE    = 1'b1,
  parameter int              XFER_FLAG     = 4,
  parameter bit              SUPERVISOR_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rspStrobe,
  input  logic                  pushStrobe,
  input  logic                  popStrobe,
  input  logic [FLAG_COUNT-1:0] flags,
  input  logic                  iBit,
  input  logic [WIDTH-1:0]      pairIn,
  output logic [WIDTH-1:0]      stackPtr,
  output logic [WIDTH-1:0]      memAddr,
  output logic [WIDTH-1:0]      pairOut,
  output logic                  pairWrite,
  output logic                  stackFault
);
  spCtrl_t ctrl;

  sp_xfer_ctrl #(
    .FLAG_COUNT(FLAG_COUNT), .ALLOW_MOVE(ALLOW_MOVE),
    .XFER_FLAG(XFER_FLAG), .SUPERVISOR_EN(SUPERVISOR_EN)
  ) u_ctrl (
    .rspStrobe(rspStrobe), .pushStrobe(pushStrobe), .popStrobe(popStrobe),
    .flags(flags), .iBit(iBit), .ctrl(ctrl)
  );

  sp_xfer_dp #(.WIDTH(WIDTH), .START_ADDR(START_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pairIn(pairIn),
    .stackPtr(stackPtr), .memAddr(memAddr), .pairOut(pairOut),
    .pairWrite(pairWrite), .stackFault(stackFault)
  );

  p_sup_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (SUPERVISOR_EN && rspStrobe && !iBit && !pushStrobe && !popStrobe)
      |=> (stackPtr == $past(stackPtr)) && !pairWrite);
  p_rsp_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspStrobe && (!SUPERVISOR_EN || iBit)) |=> !stackFault);
endmodule

// File: tb/sp_xfer_unit_test.sv
`timescale 1ns/1ps
module sp_xfer_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspStrobe = 0, pushStrobe = 0, popStrobe = 0, iBit = 0;
  logic [7:0]  flags = '0;
  logic [15:0] pairIn = '0;

  logic [15:0] spA [2];
  logic [15:0] maA [2];
  logic [15:0] poA [2];
  logic        wbA [2];
  logic        ftA [2];

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference configuration: index 0 = move/supervised, 1 = fixed/unsupervised
  bit          cfgMove [2] = '{1'b1, 1'b0};
  bit          cfgSup  [2] = '{1'b1, 1'b0};
  logic [15:0] cfgStart[2] = '{16'h0FF0, 16'h0200};
  int          cfgFlag = 4;

  logic [15:0] mSp [2];
  logic [15:0] mPo [2];
  bit          mWb [2];
  bit          mFt [2];

  always #2.5 clk = ~clk;

  sp_xfer_unit uut (
    .clk(clk), .rstN(rstN), .rspStrobe(rspStrobe), .pushStrobe(pushStrobe),
    .popStrobe(popStrobe), .flags(flags), .iBit(iBit), .pairIn(pairIn),
    .stackPtr(spA[0]), .memAddr(maA[0]), .pairOut(poA[0]),
    .pairWrite(wbA[0]), .stackFault(ftA[0])
  );

  sp_xfer_unit #(.START_ADDR(16'h0200), .ALLOW_MOVE(1'b0), .SUPERVISOR_EN(1'b0)) uutFixed (
    .clk(clk), .rstN(rstN), .rspStrobe(rspStrobe), .pushStrobe(pushStrobe),
    .popStrobe(popStrobe), .flags(flags), .iBit(iBit), .pairIn(pairIn),
    .stackPtr(spA[1]), .memAddr(maA[1]), .pairOut(poA[1]),
    .pairWrite(wbA[1]), .stackFault(ftA[1])
  );

  task automatic check(string req, string what, int inst, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", req, what, inst, act, exp);
    end
  endtask

  function automatic bit rspActive(int k);
    return rspStrobe && (!cfgSup[k] || iBit);
  endfunction

  task automatic compareRegs(string req);
    for (int k = 0; k < 2; k++) begin
      check(req, "stackPtr", k, spA[k], mSp[k]);
      check(req, "pairWrite", k, 16'(wbA[k]), 16'(mWb[k]));
      check(req, "stackFault", k, 16'(ftA[k]), 16'(mFt[k]));
      if (mWb[k]) check(req, "pairOut", k, poA[k], mPo[k]);
    end
  endtask

  task automatic step(string req, bit rsp, bit ps, bit pp, logic [7:0] fl, bit ib, logic [15:0] pr);
    rspStrobe = rsp; pushStrobe = ps; popStrobe = pp; flags = fl; iBit = ib; pairIn = pr;
    #1;
    for (int k = 0; k < 2; k++) begin
      logic [15:0] expAddr;
      expAddr = (!rspActive(k) && pp && !ps) ? mSp[k] + 16'd1 : mSp[k];
      check(req, "memAddr", k, maA[k], expAddr);
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      mWb[k] = 0;
      mFt[k] = 0;
      if (rspActive(k)) begin
        if (!cfgMove[k]) mSp[k] = cfgStart[k];
        else if (fl[cfgFlag]) mSp[k] = pr;
        else begin mWb[k] = 1; mPo[k] = mSp[k]; end
      end else if (ps && pp) mFt[k] = 1;
      else if (ps) mSp[k] = mSp[k] - 16'd1;
      else if (pp) mSp[k] = mSp[k] + 16'd1;
    end
    rspStrobe = 0; pushStrobe = 0; popStrobe = 0;
    compareRegs(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      mSp[k] = cfgStart[k]; mPo[k] = '0; mWb[k] = 0; mFt[k] = 0;
    end
    @(negedge clk);
    compareRegs("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareRegs("R1");

    // R7 / R8: pushes and pops
    step("R7", 0, 1, 0, 8'h00, 0, 16'h0);
    step("R7", 0, 1, 0, 8'h00, 0, 16'h0);
    step("R7", 0, 1, 0, 8'h00, 1, 16'h0);
    step("R8", 0, 0, 1, 8'h00, 0, 16'h0);
    step("R8", 0, 0, 1, 8'hFF, 1, 16'h0);
    // R9: collision
    step("R9", 0, 1, 1, 8'h00, 0, 16'h0);
    step("R9", 0, 0, 0, 8'h00, 0, 16'h0);
    // R6: blocked without I-bit (fixed instance has no supervisor -> R2)
    step("R6", 1, 0, 0, 8'h00, 0, 16'hAAAA);
    step("R6", 1, 0, 0, 8'h10, 0, 16'hAAAA);
    // R4: copy out, then strobe drops
    step("R4", 1, 0, 0, 8'h00, 1, 16'h5555);
    step("R4", 0, 0, 0, 8'h00, 1, 16'h5555);
    // R5: load from pair
    step("R5", 1, 0, 0, 8'h10, 1, 16'h1234);
    step("R2", 0, 1, 0, 8'h00, 0, 16'h0);
    step("R2", 1, 0, 0, 8'h10, 1, 16'h4321);
    // R3: other flag bits do not matter
    step("R3", 1, 0, 0, 8'hEF, 1, 16'h9999);
    step("R3", 1, 0, 0, 8'h10, 1, 16'h0ABC);
    step("R3", 1, 0, 0, 8'hFF, 1, 16'h0DEF);
    // R10: instruction wins over push/pop; blocked instruction lets them through
    step("R10", 1, 1, 0, 8'h00, 1, 16'h0);
    step("R10", 1, 1, 1, 8'h10, 1, 16'h7777);
    step("R10", 1, 0, 1, 8'h10, 0, 16'h7777);
    // R11: wrap
    step("R11", 1, 0, 0, 8'h10, 1, 16'hFFFF);
    step("R11", 0, 0, 1, 8'h00, 0, 16'h0);
    step("R11", 0, 1, 0, 8'h00, 0, 16'h0);
    step("R11", 0, 0, 0, 8'h00, 0, 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule